// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block gathers event strobes from a protocol engine and turns them into two interrupt request lines. Six message objects each keep a 7-bit event register: transmit done, receive done and five error kinds. A separate general register holds controller-wide events: burst complete, bus-off, four grouped error kinds and timer overrun. An enable register and a per-object mask decide which recorded events are allowed to raise the main interrupt. The overrun event drives its own line.

Software reaches all state through a byte-wide register port. Writes take effect on the clock edge and reads are combinational. The two register kinds clear in opposite ways. Object events are cleared by writing a zero, so software does a read-modify-write. General events are cleared by writing a one. An acknowledge pulse, sent when the overrun handler is entered, also clears the overrun flag.

Top module: `can_irq_agg`

## Requirements
- R1: After reset every event flag, the enable register and the object mask are zero, and both interrupt lines are low.
- R2: Object event strobe bit b of object i (bus bits i*7+b) sets bit b of that object's register at address i. The bit layout is b0 ack error, b1 form error, b2 CRC error, b3 stuff error, b4 bit error, b5 received, b6 transmitted. The bit stays set until software clears it.
- R3: A write to an object register clears the flags where the written bit is 0 and leaves unchanged the flags where it is 1. A strobe that arrives in the same cycle as a clear wins, and the flag ends up set.
- R4: General strobe bit b sets bit b of the general register at address 6. The layout is b0 overrun, b1 ack error, b2 form error, b3 CRC error, b4 stuff error, b5 burst done, b6 bus-off. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a strobe in the same cycle wins over the clear.
- R5: An `ovr_ack` pulse clears the overrun flag unless an overrun strobe arrives in the same cycle.
- R6: Object error strobes never change any general error flag.
- R7: The summary register at address 9 is read-only. Its bit i is set when mask bit i (address 8) is set and object i has at least one of the following: the receive flag with enable bit 5, the transmit flag with enable bit 4, or any error flag with enable bit 3.
- R8: The main condition is the OR of these terms: any summary bit, bus-off with enable bit 6, burst done with enable bit 2, or any general error flag with enable bit 1. Bit 7 of the general register reads this condition. `irq_can` is the condition ANDed with enable bit 7.
- R9: `irq_ovr` is high exactly when the overrun flag and enable bit 0 are both set, whatever the main condition is.
- R10: Form-error and bit-error strobes arriving together on one object are both recorded.
- R11: The enable register (address 7) and mask (address 8) read back what was written. Writes to the summary register have no effect. Addresses above 9 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| obj_evt | input | 42 | Object event strobes, 7 per object |
| gen_evt | input | 7 | General event strobes |
| ovr_ack | input | 1 | Overrun handler entry acknowledge |
| irq_can | output | 1 | Main interrupt request |
| irq_ovr | output | 1 | Timer overrun interrupt request |

## Verification
The assertions check on every cycle the rules that hold for any stimulus:
- a strobe always wins over a clear in the same cycle;
- the acknowledge removes the overrun flag;
- general error flags move only on their own strobes or writes;
- neither line is raised without its enable.

Only the bench's scenarios can show the rest:
- the exact gating of the summary bits by event class and by mask;
- the full enable-by-flag matrix of the main line and the ungated readback bit;
- the opposing clear polarities;
- the read-only summary register and the zero reads from unmapped addresses.

// File: rtl/can_irq_agg.sv
module can_irq_agg #(
  parameter int NUM_OBJ = 6,
  parameter int ADDR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic [NUM_OBJ*7-1:0] obj_evt,
  input  logic [6:0]           gen_evt,
  input  logic                 ovr_ack,
  output logic                 irq_can,
  output logic                 irq_ovr
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(NUM_OBJ);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(NUM_OBJ + 1);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(NUM_OBJ + 2);
  localparam logic [ADDR_W-1:0] SUM_A  = ADDR_W'(NUM_OBJ + 3);

  logic [6:0]         obj_q [NUM_OBJ];
  logic [6:0]         gen_q;
  logic [7:0]         en_q;
  logic [NUM_OBJ-1:0] mask_q;
  logic [NUM_OBJ-1:0] sit;
  logic               canit;

  wire gen_wr = reg_wr && reg_addr == FLAG_A;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OBJ; i++) obj_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_OBJ; i++)
        obj_q[i] <= ((reg_wr && reg_addr == ADDR_W'(i)) ? (obj_q[i] & reg_wdata[6:0]) : obj_q[i])
                    | obj_evt[i*7 +: 7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q  <= '0;
      en_q   <= '0;
      mask_q <= '0;
    end else begin
      gen_q <= ((gen_wr ? (gen_q & ~reg_wdata[6:0]) : gen_q) & ~{6'b0, ovr_ack}) | gen_evt;
      if (reg_wr && reg_addr == EN_A)   en_q   <= reg_wdata;
      if (reg_wr && reg_addr == MASK_A) mask_q <= reg_wdata[NUM_OBJ-1:0];
    end
  end

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_sit
    assign sit[g] = mask_q[g] & ((obj_q[g][5] & en_q[5]) |
                                 (obj_q[g][6] & en_q[4]) |
                                 ((|obj_q[g][4:0]) & en_q[3]));

    AST_OBJ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|obj_evt[g*7 +: 7]) |=> ((obj_q[g] & $past(obj_evt[g*7 +: 7])) == $past(obj_evt[g*7 +: 7]))); // R3
  end

  assign canit   = (|sit) | (gen_q[6] & en_q[6]) | (gen_q[5] & en_q[2]) | ((|gen_q[4:1]) & en_q[1]);
  assign irq_can = canit & en_q[7];
  assign irq_ovr = gen_q[0] & en_q[0];

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_OBJ; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = {1'b0, obj_q[i]};
    if (reg_addr == FLAG_A) reg_rdata = {canit, gen_q};
    if (reg_addr == EN_A)   reg_rdata = en_q;
    if (reg_addr == MASK_A) reg_rdata = 8'(mask_q);
    if (reg_addr == SUM_A)  reg_rdata = 8'(sit);
  end

  AST_GEN_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|gen_evt) |=> ((gen_q & $past(gen_evt)) == $past(gen_evt))); // R4
  AST_OVR_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ack && !gen_evt[0]) |=> !gen_q[0]); // R5
  AST_GEN_ERR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_evt[4:1] == 4'b0 && !gen_wr) |=> (gen_q[4:1] == $past(gen_q[4:1]))); // R6
  AST_CAN_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_can |-> en_q[7]); // R8
  AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> (gen_q[0] && en_q[0])); // R9
endmodule

// File: tb/test_can_irq_agg.sv
`timescale 1ns/1ps
module test_can_irq_agg;
  localparam int N = 6;
  logic clk = 0, rst_n = 0, reg_wr = 0, ovr_ack = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [N*7-1:0] obj_evt = 0;
  logic [6:0] gen_evt = 0;
  logic irq_can, irq_ovr;
  int checks = 0, errors = 0;

  logic [6:0] m_obj [N];
  logic [6:0] m_gen;
  logic [7:0] m_en;
  logic [N-1:0] m_mask;

  always #2.5 clk = ~clk;

  can_irq_agg #(.NUM_OBJ(N), .ADDR_W(4)) i_can_irq_agg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .obj_evt(obj_evt),
    .gen_evt(gen_evt), .ovr_ack(ovr_ack), .irq_can(irq_can), .irq_ovr(irq_ovr));

  function automatic logic [N-1:0] e_sit();
    logic [N-1:0] s;
    for (int i = 0; i < N; i++)
      s[i] = m_mask[i] && ((m_obj[i][5] && m_en[5]) || (m_obj[i][6] && m_en[4]) ||
                           (m_obj[i][4:0] != 0 && m_en[3]));
    return s;
  endfunction

  function automatic logic e_canit();
    return (e_sit() != 0) || (m_gen[6] && m_en[6]) || (m_gen[5] && m_en[2]) ||
           (m_gen[4:1] != 0 && m_en[1]);
  endfunction

  function automatic logic [7:0] e_read(input int a);
    if (a < N) return {1'b0, m_obj[a]};
    if (a == N) return {e_canit(), m_gen};
    if (a == N+1) return m_en;
    if (a == N+2) return 8'(m_mask);
    if (a == N+3) return 8'(e_sit());
    return 8'h00;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(input logic wr, input int a, input logic [7:0] d,
                      input logic [N*7-1:0] oe, input logic [6:0] ge, input logic ack);
    reg_wr = wr; reg_addr = 4'(a); reg_wdata = d; obj_evt = oe; gen_evt = ge; ovr_ack = ack;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (wr && a == i) m_obj[i] = m_obj[i] & d[6:0];
      m_obj[i] = m_obj[i] | oe[i*7 +: 7];
    end
    if (wr && a == N) m_gen = m_gen & ~d[6:0];
    if (ack) m_gen[0] = 1'b0;
    m_gen = m_gen | ge;
    if (wr && a == N+1) m_en = d;
    if (wr && a == N+2) m_mask = d[N-1:0];
    @(negedge clk);
    reg_wr = 0; obj_evt = '0; gen_evt = '0; ovr_ack = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    tick(1'b1, a, d, '0, '0, 1'b0);
  endtask

  task automatic chk_reg(input string r, input int a);
    reg_addr = 4'(a);
    #0.5;
    chk(r, reg_rdata, e_read(a));
  endtask

  task automatic chk_irq(input string r);
    chk({r, " irq_can"}, irq_can, m_en[7] && e_canit());
    chk({r, " irq_ovr"}, irq_ovr, m_gen[0] && m_en[0]);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_obj[i] = '0;
    m_gen = '0; m_en = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 12; a++) chk_reg("R1", a);
    chk_irq("R1");

    // R2 set each bit, R3 clear by writing zero
    for (int i = 0; i < N; i++)
      for (int b = 0; b < 7; b++) begin
        logic [N*7-1:0] v;
        v = '0; v[i*7+b] = 1'b1;
        tick(1'b0, 0, 8'h00, v, '0, 1'b0);
        chk_reg("R2", i);
        chk("R2 value", reg_rdata, 32'(1 << b));
        wr(i, 8'h00);
        chk_reg("R3 cleared", i);
      end

    // R3 write-one keeps, partial clear, set beats clear
    tick(1'b0, 0, 8'h00, {7'h7F, 35'h0} >> 21, '0, 1'b0);
    wr(2, 8'h7F);
    chk_reg("R3 write ones", 2);
    chk("R3 write ones value", reg_rdata, 32'h7F);
    wr(2, 8'h55);
    chk_reg("R3 partial", 2);
    chk("R3 partial value", reg_rdata, 32'h55);
    tick(1'b1, 2, 8'h00, 42'(7'h08) << 14, '0, 1'b0);
    chk_reg("R3 set wins", 2);
    chk("R3 set wins value", reg_rdata, 32'h08);
    wr(2, 8'h00);

    // R10 form and bit error together
    tick(1'b0, 0, 8'h00, 42'(7'h12) << 7, '0, 1'b0);
    chk_reg("R10", 1);
    chk("R10 value", reg_rdata, 32'h12);
    wr(1, 8'h00);

    // R6 object errors leave general flags alone
    begin
      logic [N*7-1:0] all_err;
      all_err = '0;
      for (int i = 0; i < N; i++) all_err[i*7 +: 5] = 5'h1F;
      tick(1'b0, 0, 8'h00, all_err, '0, 1'b0);
      chk_reg("R6", N);
      chk("R6 general zero", reg_rdata[6:0], 0);
      for (int i = 0; i < N; i++) wr(i, 8'h00);
    end

    // R4 general flags: set, zero-write keeps, W1C, set beats clear
    for (int b = 0; b < 7; b++) begin
      tick(1'b0, 0, 8'h00, '0, 7'(1 << b), 1'b0);
      wr(N, 8'h00);
      chk_reg("R4 set/zero write", N);
      wr(N, 8'(1 << b));
      chk_reg("R4 w1c", N);
      tick(1'b1, N, 8'(1 << b), '0, 7'(1 << b), 1'b0);
      chk_reg("R4 set wins", N);
      chk("R4 set wins bit", reg_rdata[b], 1);
      wr(N, 8'h7F);
    end

    // R5 overrun acknowledge
    wr(N+1, 8'h01);
    tick(1'b0, 0, 8'h00, '0, 7'h01, 1'b0);
    chk_irq("R9 ovr set");
    tick(1'b0, 0, 8'h00, '0, 7'h00, 1'b1);
    chk_reg("R5 ack clears", N);
    chk("R5 ovr low", irq_ovr, 0);
    tick(1'b0, 0, 8'h00, '0, 7'h01, 1'b1);
    chk_reg("R5 set beats ack", N);
    chk("R5 ovr high", irq_ovr, 1);
    wr(N, 8'h7F);

    // R7 summary sweep over object, flag, class enables and mask
    for (int i = 0; i < N; i++)
      for (int b = 0; b < 7; b++)
        for (int e = 0; e < 8; e++)
          for (int m = 0; m < 2; m++) begin
            wr(N+2, 8'(m << i));
            wr(N+1, 8'(e << 3));
            tick(1'b0, 0, 8'h00, 42'(1) << (i*7+b), '0, 1'b0);
            chk_reg("R7", N+3);
            wr(i, 8'h00);
          end
    wr(N+2, 8'h00);

    // R8 / R9 sweep over general flags and enables
    for (int f = 0; f < 128; f++) begin
      tick(1'b0, 0, 8'h00, '0, 7'(f), 1'b0);
      for (int e = 0; e < 256; e++) begin
        wr(N+1, 8'(e));
        chk_irq("R8/R9");
        reg_addr = 4'(N);
        #0.5;
        chk("R8 canit readback", reg_rdata[7], e_canit());
      end
      wr(N, 8'h7F);
    end

    // R8 summary path into main line
    wr(N+1, 8'hA0);
    tick(1'b0, 0, 8'h00, 42'(7'h20) << 28, '0, 1'b0);
    chk_irq("R8 no mask");
    wr(N+2, 8'h10);
    chk_irq("R8 masked in");
    chk("R8 main high", irq_can, 1);

    // R11 readback, read-only summary, unmapped reads
    chk_reg("R11 enable", N+1);
    chk_reg("R11 mask", N+2);
    wr(N+3, 8'h00);
    chk_reg("R11 summary ro", N+3);
    chk("R11 summary kept", reg_rdata, 32'h10);
    for (int a = N+4; a < 16; a++) chk_reg("R11 unmapped", a);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule